// File: doc/BRIEF.md
# Low-Power Clock Sequencer

This controller steps a processor core into and out of two sleep levels. In the light level (STANDBY), only the system and peripheral clocks stop. In the deep level (HALT), the PLL and oscillator domain also stops. The CPU raises `idle_req` together with a level select, a clock-divider code and a boot-memory flag. The block first gives the pipeline time to drain. It then drops the clock enables that belong to the chosen level.

While the block is asleep, it watches a GPIO wake line and a reset-pin wake line. Each line passes through a two-flop synchronizer. A wake is taken only after a short guard time since entry, and only if the line stays high for a minimum number of cycles. The minimum depends on the level and on which line is used.

On leaving STANDBY, all enables come back at once and a one-cycle wake interrupt is raised. On leaving HALT, the block turns the oscillator domain back on and waits for PLL lock, or for a timeout. It then counts a resume latency that is long for flash and short for on-chip RAM. Last, it raises a one-cycle resume strobe.

All counting uses `clk`, an always-on reference clock. The oscillator start-up time is a parameter given in these cycles.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: A synchronous reset (rst=1) puts the block in the running state. In that state sys_clk_en, per_clk_en, pll_osc_en and clkout_en are all 1, and wake_irq and resume are 0.
- R2: A request is accepted when idle_req=1 is sampled while running. sys_clk_en then stays 1 for exactly 16 cycles after the accepting edge when div_sel is 2'b00 or 2'b01, 32 cycles when it is 2'b10, and 64 cycles when it is 2'b11. It is 0 after that.
- R3: With mode_halt=0 (STANDBY), per_clk_en drops together with sys_clk_en. pll_osc_en stays 1, and clkout_en follows sys_clk_en.
- R4: With mode_halt=1 (HALT), sys_clk_en, per_clk_en and pll_osc_en are all 0 once the drain time ends. clkout_en stays 1 for 36 cycles after the accepting edge and is 0 from then on, until the block is running again.
- R5: A wake line is ignored until 5 cycles have passed since the accepting edge. Synchronized high cycles seen before that do not count toward its width.
- R6: After synchronization, a wake line must stay high for a minimum number of consecutive cycles to be taken. The minimum is 3 cycles for the GPIO line in STANDBY, OSC_START+2 cycles (10 by default) for the GPIO line in HALT, and OSC_START+8 cycles (16 by default) for the reset-pin line in HALT. A shorter pulse is dropped and the block stays asleep.
- R7: The reset-pin wake line has no effect in STANDBY.
- R8: A wake taken in STANDBY returns the block to running on the next cycle. In that same cycle, wake_irq is 1 for exactly one cycle and all enables are 1.
- R9: A wake taken in HALT sets pll_osc_en to 1 while sys_clk_en stays 0. This lasts until pll_lock=1 is sampled or LOCK_TIMEOUT (2000) cycles have passed.
- R10: After lock, sys_clk_en is 1 for a resume latency of 1125 cycles if boot_flash was 1 at the request, or 35 cycles if it was 0. Then the block is running and resume is 1 for exactly one cycle.
- R11: idle_req has no effect while a low-power sequence is in progress.
- R12: A wake that meets its width while the pipeline is still draining is held. The block then leaves the low-power level one cycle after entering it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst | input | 1 | Synchronous reset, active high |
| idle_req | input | 1 | Low-power request from the CPU |
| mode_halt | input | 1 | 1 selects HALT, 0 selects STANDBY (sampled with the request) |
| div_sel | input | 2 | Clock-divider code that sets the drain length |
| boot_flash | input | 1 | 1 if execution resumes from flash (sampled with the request) |
| wake_gpio | input | 1 | Asynchronous GPIO wake line |
| wake_rstpin | input | 1 | Asynchronous reset-pin wake line (HALT only) |
| pll_lock | input | 1 | PLL lock indication |
| sys_clk_en | output | 1 | System clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pll_osc_en | output | 1 | PLL, oscillator and watchdog domain enable |
| clkout_en | output | 1 | External clock output enable |
| wake_irq | output | 1 | One-cycle pulse on STANDBY exit |
| resume | output | 1 | One-cycle pulse when HALT resume completes |

## Verification
Suppose the drain counter or the level latch is wrong. Then sys_clk_en or pll_osc_en falls at the wrong cycle, and this shows within one clock of the correct edge. A wrong width count, or a guard that opens early or late, shows as an exit that comes too soon or never comes. The bench sees this at the enables within a few cycles after the pulse ends. A wrong resume or lock count only appears at the end of the latency, when resume rises early or late. So the bench compares every output against its model on every cycle, not only at the end of a scenario.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_FLUSH  = 3'd1,
    ST_STBY   = 3'd2,
    ST_HALT   = 3'd3,
    ST_LOCK   = 3'd4,
    ST_RESUME = 3'd5
  } lpm_state_e;

  // Drain length in cycles for each divider code.
  function automatic int unsigned flush_cycles(input logic [1:0] code);
    case (code)
      2'b11:   return 64;
      2'b10:   return 32;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/lpm_sync2.sv
module lpm_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          lvl,
  input  logic [QW-1:0] thr,
  output logic          hit
);
  logic [QW-1:0] run_len;

  // Counts armed high cycles seen before the current one.
  always_ff @(posedge clk) begin
    if (rst || !arm || !lvl)
      run_len <= '0;
    else if (run_len != {QW{1'b1}})
      run_len <= run_len + 1'b1;
  end

  assign hit = arm && lvl && (run_len == thr - 1'b1);

  // R6
  wake_width_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && thr > 1) |-> ($past(lvl) && $past(arm)));
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int OSC_START    = 8,
  parameter int STBY_WAKE_W  = 3,
  parameter int GUARD        = 5,
  parameter int CLKOUT_DLY   = 36,
  parameter int LOCK_TIMEOUT = 2000,
  parameter int FLASH_RESUME = 1125,
  parameter int RAM_RESUME   = 35
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       idle_req,
  input  logic       mode_halt,
  input  logic [1:0] div_sel,
  input  logic       boot_flash,
  input  logic       wake_gpio,
  input  logic       wake_rstpin,
  input  logic       pll_lock,
  output logic       sys_clk_en,
  output logic       per_clk_en,
  output logic       pll_osc_en,
  output logic       clkout_en,
  output logic       wake_irq,
  output logic       resume
);
  localparam int NWAKE = 2;
  localparam int QW    = 8;
  localparam int SW    = 8;
  localparam logic [QW-1:0] THR_STBY   = QW'(STBY_WAKE_W);
  localparam logic [QW-1:0] THR_H_GPIO = QW'(OSC_START + 2);
  localparam logic [QW-1:0] THR_H_RST  = QW'(OSC_START + 8);
  localparam logic [SW-1:0] SINCE_MAX  = {SW{1'b1}};

  lpm_state_e     state;
  logic [CNT_W-1:0] cnt, flush_len_q, resume_len_q;
  logic [SW-1:0]  since;
  logic           halt_sel, wake_pend;

  logic [NWAKE-1:0] wake_raw, wake_sync, arm, hit;
  logic [QW-1:0]    thr [NWAKE];

  // Named internal events.
  logic lp_active, lp_armed, flush_done, lock_done, resume_done, wake_go;

  assign wake_raw = {wake_rstpin, wake_gpio};
  assign lp_active = (state == ST_FLUSH) || (state == ST_STBY) || (state == ST_HALT);
  assign lp_armed  = lp_active && (since >= SW'(GUARD));
  assign arm[0]    = lp_armed;
  assign arm[1]    = lp_armed && halt_sel;
  assign thr[0]    = halt_sel ? THR_H_GPIO : THR_STBY;
  assign thr[1]    = THR_H_RST;

  generate
    for (genvar i = 0; i < NWAKE; i++) begin : g_wake
      lpm_sync2 u_sync (
        .clk (clk), .rst (rst), .d (wake_raw[i]), .q (wake_sync[i])
      );
      lpm_wake_qual #(.QW(QW)) u_qual (
        .clk (clk), .rst (rst), .arm (arm[i]), .lvl (wake_sync[i]),
        .thr (thr[i]), .hit (hit[i])
      );
    end
  endgenerate

  assign wake_go     = (|hit) || wake_pend;
  assign flush_done  = (state == ST_FLUSH) && (cnt == flush_len_q - 1'b1);
  assign lock_done   = (state == ST_LOCK) &&
                       (pll_lock || (cnt == CNT_W'(LOCK_TIMEOUT - 1)));
  assign resume_done = (state == ST_RESUME) && (cnt == resume_len_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_RUN;
      cnt          <= '0;
      since        <= '0;
      halt_sel     <= 1'b0;
      wake_pend    <= 1'b0;
      flush_len_q  <= CNT_W'(16);
      resume_len_q <= CNT_W'(RAM_RESUME);
      wake_irq     <= 1'b0;
      resume       <= 1'b0;
    end else begin
      wake_irq  <= (state == ST_STBY) && wake_go;
      resume    <= resume_done;
      since     <= (state == ST_RUN) ? '0 :
                   (since == SINCE_MAX) ? since : since + 1'b1;
      wake_pend <= (state == ST_RUN) ? 1'b0 :
                   (wake_pend || ((state == ST_FLUSH) && (|hit)));
      case (state)
        ST_RUN: if (idle_req) begin
          state        <= ST_FLUSH;
          cnt          <= '0;
          halt_sel     <= mode_halt;
          flush_len_q  <= CNT_W'(flush_cycles(div_sel));
          resume_len_q <= boot_flash ? CNT_W'(FLASH_RESUME) : CNT_W'(RAM_RESUME);
        end
        ST_FLUSH: begin
          cnt <= cnt + 1'b1;
          if (flush_done) begin
            state <= halt_sel ? ST_HALT : ST_STBY;
            cnt   <= '0;
          end
        end
        ST_STBY: if (wake_go) state <= ST_RUN;
        ST_HALT: if (wake_go) begin
          state <= ST_LOCK;
          cnt   <= '0;
        end
        ST_LOCK: begin
          cnt <= cnt + 1'b1;
          if (lock_done) begin
            state <= ST_RESUME;
            cnt   <= '0;
          end
        end
        ST_RESUME: begin
          cnt <= cnt + 1'b1;
          if (resume_done) begin
            state <= ST_RUN;
            cnt   <= '0;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    sys_clk_en = (state == ST_RUN) || (state == ST_FLUSH) || (state == ST_RESUME);
    per_clk_en = (state == ST_RUN) || (state == ST_FLUSH);
    pll_osc_en = (state != ST_HALT);
    if ((state == ST_RUN) || (state == ST_RESUME))
      clkout_en = 1'b1;
    else if (!halt_sel)
      clkout_en = sys_clk_en;
    else
      clkout_en = (since < SW'(CLKOUT_DLY));
  end

  // R2
  flush_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_clk_en) |-> $past(flush_done));

  // R4
  halt_off_chk: assert property (@(posedge clk) disable iff (rst)
    !pll_osc_en |-> (!sys_clk_en && !per_clk_en));

  // R5
  guard_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_irq) |-> ($past(since) >= SW'(GUARD)));

  // R8
  irq_chk: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> (sys_clk_en && per_clk_en && pll_osc_en));

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK && !lock_done) |=> (state == ST_LOCK && !sys_clk_en && pll_osc_en));

  // R10
  resume_chk: assert property (@(posedge clk) disable iff (rst)
    resume |-> ($past(state) == ST_RESUME && state == ST_RUN));

  // R11
  idle_ign_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN && state != ST_FLUSH && idle_req) |=> (state != ST_FLUSH));
endmodule

// File: tb/tb_lpm_clk_ctrl.sv
module tb_lpm_clk_ctrl;
  localparam int OSC_START = 8;
  localparam int GUARD = 5;
  localparam int CLKOUT_DLY = 36;
  localparam int LOCK_TO = 2000;

  logic clk = 0, rst = 1, idle_req = 0, mode_halt = 0, boot_flash = 0;
  logic [1:0] div_sel = 0;
  logic wake_gpio = 0, wake_rstpin = 0, pll_lock = 0;
  logic sys_clk_en, per_clk_en, pll_osc_en, clkout_en, wake_irq, resume;

  int checks = 0, errors = 0, cyc = 0;
  bit started = 0, done = 0;

  lpm_clk_ctrl dut (
    .clk(clk), .rst(rst), .idle_req(idle_req), .mode_halt(mode_halt),
    .div_sel(div_sel), .boot_flash(boot_flash), .wake_gpio(wake_gpio),
    .wake_rstpin(wake_rstpin), .pll_lock(pll_lock), .sys_clk_en(sys_clk_en),
    .per_clk_en(per_clk_en), .pll_osc_en(pll_osc_en), .clkout_en(clkout_en),
    .wake_irq(wake_irq), .resume(resume)
  );

  always #4 clk = ~clk;  // 125 MHz

  // Behavioural reference: phase 0 awake, 1 draining, 2 light sleep,
  // 3 deep sleep, 4 awaiting lock, 5 resume latency.
  int ph, tick, since, drain, lat, gseen, rseen;
  bit deep, pend, e_sys, e_per, e_pll, e_co, e_irq, e_res;
  bit gq[$], rq[$];

  always @(posedge clk) begin
    bit gs, rs, armed, hg, hr, wk;
    int nph, nsince, need_g;
    cyc++;
    if (rst) begin
      ph = 0; since = 0; pend = 0; gseen = 0; rseen = 0; deep = 0;
      gq = '{0, 0}; rq = '{0, 0};
    end else begin
      gs = gq.pop_front(); gq.push_back(wake_gpio);
      rs = rq.pop_front(); rq.push_back(wake_rstpin);
      armed = (ph >= 1 && ph <= 3) && since >= GUARD;
      gseen = (armed && gs) ? gseen + 1 : 0;
      rseen = (armed && deep && rs) ? rseen + 1 : 0;
      need_g = deep ? OSC_START + 2 : 3;
      hg = armed && gs && gseen == need_g;
      hr = armed && deep && rs && rseen == OSC_START + 8;
      wk = hg || hr || pend;
      e_irq = (ph == 2) && wk;
      e_res = 0;
      nsince = (ph == 0) ? 0 : since + 1;
      if (ph == 0) pend = 0; else if (ph == 1 && (hg || hr)) pend = 1;
      nph = ph;
      case (ph)
        0: if (idle_req) begin
             nph = 1; tick = 0; deep = mode_halt;
             drain = (div_sel == 3) ? 64 : (div_sel == 2) ? 32 : 16;
             lat = boot_flash ? 1125 : 35;
           end
        1: begin tick++; if (tick == drain) nph = deep ? 3 : 2; end
        2: if (wk) nph = 0;
        3: if (wk) begin nph = 4; tick = 0; end
        4: begin tick++; if (pll_lock || tick == LOCK_TO) begin nph = 5; tick = 0; end end
        5: begin tick++; if (tick == lat) begin nph = 0; e_res = 1; end end
        default: nph = 0;
      endcase
      ph = nph; since = nsince;
    end
    e_sys = (ph == 0 || ph == 1 || ph == 5);
    e_per = (ph == 0 || ph == 1);
    e_pll = (ph != 3);
    if (ph == 0 || ph == 5) e_co = 1;
    else if (!deep) e_co = e_sys;
    else e_co = (since < CLKOUT_DLY);
    if (rst) begin e_irq = 0; e_res = 0; end
    started = 1;
  end

  task automatic cmp(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d got %0b exp %0b", tag, cyc, got, exp);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    cmp("R2 sys_clk_en", sys_clk_en, e_sys);
    cmp("R3 per_clk_en", per_clk_en, e_per);
    cmp("R4 pll_osc_en", pll_osc_en, e_pll);
    cmp("R4 clkout_en", clkout_en, e_co);
    cmp("R8 wake_irq", wake_irq, e_irq);
    cmp("R10 resume", resume, e_res);
  end

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 100000 && !done) begin
    errors++;
    $display("FAIL watchdog cycle %0d got hung exp finished", cyc);
    finish_run();
  end

  task automatic enter(input bit h, input logic [1:0] d, input bit fl);
    @(negedge clk);
    idle_req = 1; mode_halt = h; div_sel = d; boot_flash = fl;
    @(negedge clk);
    idle_req = 0;
  endtask

  task automatic pulse(input bit rpin, input int w);
    @(negedge clk);
    if (rpin) wake_rstpin = 1; else wake_gpio = 1;
    repeat (w) @(negedge clk);
    wake_rstpin = 0; wake_gpio = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    cmp("R1 sys", sys_clk_en, 1); cmp("R1 per", per_clk_en, 1);
    cmp("R1 pll", pll_osc_en, 1); cmp("R1 irq", wake_irq, 0);

    // STANDBY div 00: short pulse dropped (R6), reset-pin ignored (R7)
    enter(0, 2'b00, 0);
    idle(30);
    pulse(0, 2); idle(8);
    cmp("R6 short stby pulse", sys_clk_en, 0);
    pulse(1, 25); idle(8);
    cmp("R7 rstpin in stby", sys_clk_en, 0);
    cmp("R3 pll kept", pll_osc_en, 1);
    pulse(0, 5); idle(6);
    cmp("R8 awake", per_clk_en, 1);

    // STANDBY div 10 with repeated request mid-sequence (R11)
    enter(0, 2'b10, 0);
    idle(10);
    @(negedge clk) idle_req = 1;
    @(negedge clk) idle_req = 0;
    idle(40);
    cmp("R11 still asleep", sys_clk_en, 0);
    @(negedge clk) idle_req = 1;
    @(negedge clk) idle_req = 0;
    pulse(0, 4); idle(6);
    cmp("R11 woke normally", sys_clk_en, 1);

    // STANDBY div 11, wake met during drain is held (R12)
    enter(0, 2'b11, 0);
    idle(8);
    pulse(0, 6); idle(70);
    cmp("R12 held wake", sys_clk_en, 1);

    // STANDBY div 01, pulse straddling guard is dropped (R5)
    enter(0, 2'b01, 0);
    pulse(0, 4); idle(30);
    cmp("R5 guard", sys_clk_en, 0);
    pulse(0, 3); idle(6);

    // HALT div 00 from RAM: short GPIO dropped, lock, 35-cycle resume (R9 R10)
    enter(1, 2'b00, 0);
    idle(60);
    pulse(0, 9); idle(8);
    cmp("R6 short halt gpio", pll_osc_en, 0);
    pulse(0, 12); idle(10);
    cmp("R9 pll on", pll_osc_en, 1);
    cmp("R9 sys off", sys_clk_en, 0);
    @(negedge clk) pll_lock = 1;
    idle(4); pll_lock = 0;
    idle(60);
    cmp("R10 ram resume done", per_clk_en, 1);

    // HALT div 11 from flash: reset-pin wake, lock timeout (R6 R9 R10)
    enter(1, 2'b11, 1);
    idle(80);
    pulse(1, 15); idle(8);
    cmp("R6 short rstpin", pll_osc_en, 0);
    pulse(1, 20); idle(LOCK_TO + 1200);
    cmp("R10 flash resume done", sys_clk_en, 1);

    // HALT div 10 from flash, lock already present
    enter(1, 2'b10, 1);
    idle(50);
    pll_lock = 1;
    pulse(0, 12); idle(1200);
    pll_lock = 0;
    cmp("R10 flash quick lock", per_clk_en, 1);
    idle(5);
    finish_run();
  end
endmodule